// File: doc/BRIEF.md
# Byte-Programmed DMA Channel Register Unit

This block is a single programmable DMA channel as it appears behind the narrow byte-wide register port of a classic personal-computer DMA controller. Software programs a 16-bit transfer address, a separate page byte and a 16-bit count. The two 16-bit registers are reached one byte at a time through one byte pointer shared by both. A mode byte picks the transfer direction code, the transfer type, auto-initialize and address decrement. Separate port writes set or clear the channel mask and a software request bit.

Once the channel is unmasked and a request is present, the channel requests service. Each transfer strobe from the bus side then steps the current address and the current count. The strobe on which the count passes through zero is the terminal one: a one-cycle terminal-count pulse follows. The channel then either reloads from its base registers (auto-initialize) or masks itself. Three named states run the channel. `ST_IDLE` means there is no service. `ST_SERVE` means the channel is requesting and accepting strobes. `ST_TERM` is the one cycle that follows the terminal transfer. The transitions are: IDLE→SERVE when a request becomes valid; SERVE→TERM on the terminal strobe; SERVE→IDLE when the request is lost; TERM→SERVE if a request is still valid, otherwise TERM→IDLE.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the mask is set, `chan_req` and `tc_pulse` are 0, the byte pointer selects the low byte, and address, count, page and mode are all zero.
- R2: Any write with `reg_sel`=6 resets the byte pointer. Every read or write with `reg_sel`=0 (address) or 1 (count) reaches the low byte when the pointer is clear and the high byte when it is set, and then toggles the pointer. The pointer is shared by the address and count registers.
- R3: A write with `reg_sel`=0 or 1 loads the selected byte into both the base and the current register. Reads return the current register.
- R4: The page byte (`reg_sel`=2) changes only when it is written. Stepping the address word past 0xFFFF or below 0x0000 wraps within the 16 bits and never carries into the page.
- R5: Each accepted strobe increments the current address, or decrements it when mode bit 5 is set, and decrements the current count by one.
- R6: The count holds length minus one. The strobe accepted while the current count is 0 is the terminal transfer, and `tc_pulse` is 1 for exactly the following cycle. Without auto-initialize, the current count then reads 0xFFFF.
- R7: With auto-initialize (mode bit 4), the terminal transfer reloads the current address and count from the base registers. The mask stays clear, and `chan_req` returns one cycle after the pulse.
- R8: Without auto-initialize, the terminal transfer sets the mask, and `chan_req` drops.
- R9: A write with `reg_sel`=3, 4 or 5 takes effect only when data bits [1:0] equal `CHAN_ID`. Mode bits [3:2] are the direction code (00 verify, 01 write, 10 read, 11 accepted as well) and appear on `xfer_dir`.
- R10: A write with `reg_sel`=4 masks the channel when data bit 2 is 1 and unmasks it when bit 2 is 0. While the channel is masked, `chan_req` is 0 one cycle later.
- R11: A write with `reg_sel`=5 sets the software request when data bit 2 is 1 and clears it when bit 2 is 0. A software request is honoured only when mode bits [7:6] are 10 (block); 00 demand, 01 single and 11 cascade ignore it. `hw_dreq` is honoured in every type.
- R12: `chan_req` rises one cycle after a request becomes valid on an unmasked channel. Strobes while `chan_req` is 0 change neither the address nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (advances the byte pointer) |
| reg_sel | input | 3 | 0 addr, 1 count, 2 page, 3 mode, 4 mask, 5 request, 6 pointer clear |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the selected register |
| hw_dreq | input | 1 | Hardware request from the peripheral |
| xfer_strobe | input | 1 | One transfer completed on the bus |
| chan_req | output | 1 | Channel requests bus service |
| tc_pulse | output | 1 | Terminal count, one cycle |
| mem_addr | output | 24 | Page byte joined with the current address word |
| xfer_dir | output | 2 | Direction code from the mode byte |

## Verification
The byte port is driven by a table of interleaved address, count and page accesses. Some pointer clears are omitted, so an error in the sharing of the pointer between address and count shows up as a wrong byte. Transfers are run in three ways: incrementing without auto-initialize, decrementing with auto-initialize, and across both 16-bit wrap points. Together these separate self-masking from reloading, up-stepping from down-stepping, and a correct page from one that takes a carry. The request tests compare a software request against a hardware request in single mode and in block mode, and include port writes that carry another channel's number, which must change nothing.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        SEL_ADDR  = 3'd0,
        SEL_COUNT = 3'd1,
        SEL_PAGE  = 3'd2,
        SEL_MODE  = 3'd3,
        SEL_MASK  = 3'd4,
        SEL_REQ   = 3'd5,
        SEL_FFCLR = 3'd6,
        SEL_NONE  = 3'd7
    } port_sel_e;

    typedef enum logic [1:0] {
        XT_DEMAND  = 2'b00,
        XT_SINGLE  = 2'b01,
        XT_BLOCK   = 2'b10,
        XT_CASCADE = 2'b11
    } xfer_type_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_TERM  = 2'd2
    } chan_state_e;

    // mode byte bits [7:2]; bits [1:0] only address the channel
    typedef struct packed {
        xfer_type_e ttype;
        logic       dec;
        logic       auto_init;
        logic [1:0] dir;
    } mode_t;

endpackage

// File: rtl/dma_word_reg.sv
module dma_word_reg #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_lo,
    input  logic            ld_hi,
    input  logic [BW-1:0]   wbyte,
    input  logic            step,
    input  logic            down,
    input  logic            reload,
    output logic [2*BW-1:0] cur,
    output logic [2*BW-1:0] base
);
    localparam int W = 2 * BW;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= '0;
            base <= '0;
        end else if (ld_lo) begin
            cur[BW-1:0]  <= wbyte;
            base[BW-1:0] <= wbyte;
        end else if (ld_hi) begin
            cur[W-1:BW]  <= wbyte;
            base[W-1:BW] <= wbyte;
        end else if (reload) begin
            cur <= base;
        end else if (step) begin
            cur <= down ? cur - W'(1) : cur + W'(1);
        end
    end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_ok,
    input  logic strobe,
    input  logic cnt_zero,
    output logic chan_req,
    output logic tc_pulse,
    output logic step_en,
    output logic tc_hit
);
    chan_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_ok) state_d = ST_SERVE;
            ST_SERVE: begin
                if (tc_hit)       state_d = ST_TERM;
                else if (!req_ok) state_d = ST_IDLE;
            end
            ST_TERM:  state_d = req_ok ? ST_SERVE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        chan_req = (state_q == ST_SERVE);
        tc_pulse = (state_q == ST_TERM);
        step_en  = strobe && (state_q == ST_SERVE);
        tc_hit   = step_en && cnt_zero;
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int CHAN_ID = 1,
    parameter int BW      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [2:0]      reg_sel,
    input  logic [BW-1:0]   wdata,
    output logic [BW-1:0]   rdata,
    input  logic            hw_dreq,
    input  logic            xfer_strobe,
    output logic            chan_req,
    output logic            tc_pulse,
    output logic [3*BW-1:0] mem_addr,
    output logic [1:0]      xfer_dir
);
    localparam int W = 2 * BW;

    port_sel_e       sel;
    logic            ptr_q, mask_q, sw_req_q, chan_match;
    logic [BW-1:0]   page_q;
    mode_t           mode_q;
    logic            step_en, tc_hit, req_ok;
    logic [W-1:0]    cur_w  [2];
    logic [W-1:0]    base_w [2];
    logic [W-1:0]    addr_cur, cnt_cur, cnt_base;

    assign sel        = port_sel_e'(reg_sel);
    assign chan_match = (wdata[1:0] == 2'(CHAN_ID));

    // shared byte pointer
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= 1'b0;
        else if (wr_en && sel == SEL_FFCLR)
            ptr_q <= 1'b0;
        else if ((wr_en || rd_en) && (sel == SEL_ADDR || sel == SEL_COUNT))
            ptr_q <= ~ptr_q;
    end

    // index 0: address word, index 1: count word
    for (genvar gi = 0; gi < 2; gi++) begin : g_word
        localparam port_sel_e MY_SEL = (gi == 0) ? SEL_ADDR : SEL_COUNT;
        logic hit;
        assign hit = wr_en && (sel == MY_SEL);
        dma_word_reg #(.BW(BW)) u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_lo  (hit && !ptr_q),
            .ld_hi  (hit && ptr_q),
            .wbyte  (wdata),
            .step   (step_en && !(tc_hit && mode_q.auto_init)),
            .down   ((gi == 1) ? 1'b1 : mode_q.dec),
            .reload (tc_hit && mode_q.auto_init),
            .cur    (cur_w[gi]),
            .base   (base_w[gi])
        );
    end

    assign addr_cur = cur_w[0];
    assign cnt_cur  = cur_w[1];
    assign cnt_base = base_w[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q   <= '0;
            mode_q   <= '0;
            mask_q   <= 1'b1;
            sw_req_q <= 1'b0;
        end else begin
            if (wr_en && sel == SEL_PAGE)
                page_q <= wdata;
            if (wr_en && sel == SEL_MODE && chan_match)
                mode_q <= mode_t'(wdata[7:2]);
            if (wr_en && sel == SEL_MASK && chan_match)
                mask_q <= wdata[2];
            else if (tc_hit && !mode_q.auto_init)
                mask_q <= 1'b1;
            if (wr_en && sel == SEL_REQ && chan_match)
                sw_req_q <= wdata[2];
        end
    end

    assign req_ok = !mask_q &&
                    (hw_dreq || (sw_req_q && mode_q.ttype == XT_BLOCK));

    dma_xfer_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_ok   (req_ok),
        .strobe   (xfer_strobe),
        .cnt_zero (cnt_cur == '0),
        .chan_req (chan_req),
        .tc_pulse (tc_pulse),
        .step_en  (step_en),
        .tc_hit   (tc_hit)
    );

    always_comb begin
        unique case (sel)
            SEL_ADDR:  rdata = ptr_q ? addr_cur[W-1:BW] : addr_cur[BW-1:0];
            SEL_COUNT: rdata = ptr_q ? cnt_cur[W-1:BW]  : cnt_cur[BW-1:0];
            SEL_PAGE:  rdata = page_q;
            default:   rdata = '0;
        endcase
    end

    assign mem_addr = {page_q, addr_cur};
    assign xfer_dir = mode_q.dir;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [2:0]   reg_sel,
    input logic         tc_pulse,
    input logic         chan_req,
    input logic         mask_q,
    input logic         auto_q,
    input logic         dec_q,
    input logic         step_en,
    input logic         tc_hit,
    input logic [W-1:0] addr_cur,
    input logic [W-1:0] cnt_cur,
    input logic [W-1:0] cnt_base,
    input logic [7:0]   page_q
);
    AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse); // R6
    AST_COUNT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && !auto_q) |-> (cnt_cur == {W{1'b1}})); // R6
    AST_RELOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && auto_q) |-> (cnt_cur == cnt_base)); // R7
    AST_SELF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && !auto_q) |-> mask_q); // R8
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |=> !chan_req); // R10
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_sel == 3'd2) |=> $stable(page_q)); // R4
    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !(wr_en && reg_sel == 3'd1)) |=> $stable(cnt_cur)); // R12
    AST_ADDR_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !tc_hit && !dec_q && !(wr_en && reg_sel == 3'd0))
        |=> (addr_cur == $past(addr_cur) + W'(1))); // R5
endmodule

bind dma_chan_regs dma_chan_chk #(.W(2 * BW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .reg_sel  (reg_sel),
    .tc_pulse (tc_pulse),
    .chan_req (chan_req),
    .mask_q   (mask_q),
    .auto_q   (mode_q.auto_init),
    .dec_q    (mode_q.dec),
    .step_en  (step_en),
    .tc_hit   (tc_hit),
    .addr_cur (addr_cur),
    .cnt_cur  (cnt_cur),
    .cnt_base (cnt_base),
    .page_q   (page_q)
);

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  reg_sel = 3'd7;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        hw_dreq = 1'b0, xfer_strobe = 1'b0;
    logic        chan_req, tc_pulse;
    logic [23:0] mem_addr;
    logic [1:0]  xfer_dir;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_chan_regs #(.CHAN_ID(1), .BW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
        .hw_dreq(hw_dreq), .xfer_strobe(xfer_strobe),
        .chan_req(chan_req), .tc_pulse(tc_pulse),
        .mem_addr(mem_addr), .xfer_dir(xfer_dir)
    );

    // {rd, sel[2:0], wdata[7:0], expected[7:0]}
    localparam int NV = 22;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 3'd6, 8'h00, 8'h00}, {1'b0, 3'd0, 8'h34, 8'h00},
        {1'b0, 3'd0, 8'h12, 8'h00}, {1'b0, 3'd2, 8'h05, 8'h00},
        {1'b0, 3'd1, 8'h03, 8'h00}, {1'b0, 3'd1, 8'h00, 8'h00},
        {1'b0, 3'd6, 8'h00, 8'h00}, {1'b1, 3'd0, 8'h00, 8'h34},
        {1'b1, 3'd0, 8'h00, 8'h12}, {1'b1, 3'd1, 8'h00, 8'h03},
        {1'b1, 3'd1, 8'h00, 8'h00}, {1'b1, 3'd2, 8'h00, 8'h05},
        {1'b0, 3'd6, 8'h00, 8'h00}, {1'b1, 3'd0, 8'h00, 8'h34},
        {1'b1, 3'd1, 8'h00, 8'h00}, {1'b0, 3'd6, 8'h00, 8'h00},
        {1'b0, 3'd0, 8'h78, 8'h00}, {1'b0, 3'd6, 8'h00, 8'h00},
        {1'b0, 3'd0, 8'h9A, 8'h00}, {1'b0, 3'd6, 8'h00, 8'h00},
        {1'b1, 3'd0, 8'h00, 8'h9A}, {1'b1, 3'd0, 8'h00, 8'h12}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; reg_sel = 3'd7;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; reg_sel = s;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; reg_sel = 3'd7;
    endtask

    task automatic rd16(input logic [2:0] s, output logic [15:0] v);
        logic [7:0] lo, hi;
        wr(3'd6, 8'h00);
        rd(s, lo);
        rd(s, hi);
        v = {hi, lo};
    endtask

    task automatic wr16(input logic [2:0] s, input logic [15:0] v);
        wr(3'd6, 8'h00);
        wr(s, v[7:0]);
        wr(s, v[15:8]);
    endtask

    task automatic strobe();
        @(negedge clk);
        xfer_strobe = 1'b1;
        @(negedge clk);
        xfer_strobe = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 chan_req", chan_req, 0);
        check("R1 tc_pulse", tc_pulse, 0);
        check("R1 mem_addr", mem_addr, 0);
        check("R1 xfer_dir", xfer_dir, 0);
        rd(3'd0, b);
        check("R1 addr low", b, 0);
        rd(3'd1, b);
        check("R1 count high", b, 0);

        // R2 R3 byte-port table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) begin
                rd(VEC[i][18:16], b);
                check($sformatf("R2 R3 vector %0d", i), b, VEC[i][7:0]);
            end else begin
                wr(VEC[i][18:16], VEC[i][15:8]);
            end
        end

        // R11 software request only in block mode
        wr(3'd3, 8'h49);           // single, dir 10, ch1
        wr(3'd4, 8'h01);           // unmask
        wr(3'd5, 8'h05);           // sw request
        idle(); idle();
        check("R11 sw req single", chan_req, 0);
        check("R9 dir read", xfer_dir, 2);
        wr(3'd3, 8'h89);           // block
        idle();
        check("R11 sw req block", chan_req, 1);
        wr(3'd5, 8'h01);           // withdraw
        idle();
        check("R11 withdraw", chan_req, 0);
        wr(3'd3, 8'h49);
        hw_dreq = 1'b1;
        idle(); idle();
        check("R11 hw req single", chan_req, 1);

        // R9 other-channel writes ignored
        wr(3'd3, 8'h84);
        check("R9 mode other ch", xfer_dir, 2);
        wr(3'd4, 8'h04);           // mask ch0
        idle();
        check("R9 mask other ch", chan_req, 1);
        wr(3'd3, 8'h0D);
        check("R9 dir code 11", xfer_dir, 3);
        hw_dreq = 1'b0;
        idle();

        // R5 R6 R8 transfer, increment, no auto-init
        wr(3'd3, 8'h89);
        wr16(3'd0, 16'h1234);
        wr(3'd2, 8'h05);
        wr16(3'd1, 16'h0002);
        wr(3'd5, 8'h05);
        idle();
        check("R12 request rise", chan_req, 1);
        strobe();
        check("R5 addr up", mem_addr, 24'h051235);
        strobe();
        check("R6 no early tc", tc_pulse, 0);
        strobe();
        check("R6 tc pulse", tc_pulse, 1);
        idle();
        check("R6 tc width", tc_pulse, 0);
        check("R8 self mask", chan_req, 0);
        rd16(3'd1, w);
        check("R6 count ffff", w, 16'hFFFF);
        strobe();
        rd16(3'd0, w);
        check("R12 strobe ignored", w, 16'h1237);

        // R7 auto-init with decrement
        wr(3'd3, 8'hB9);
        wr16(3'd0, 16'h0001);
        wr(3'd2, 8'h07);
        wr16(3'd1, 16'h0001);
        wr(3'd4, 8'h01);
        idle();
        strobe();
        check("R5 addr down", mem_addr, 24'h070000);
        strobe();
        check("R7 tc pulse", tc_pulse, 1);
        idle();
        check("R7 stays unmasked", chan_req, 1);
        check("R7 addr reload", mem_addr, 24'h070001);
        rd16(3'd1, w);
        check("R7 count reload", w, 16'h0001);

        // R4 wrap without page carry
        wr(3'd3, 8'hA9);
        wr16(3'd0, 16'h0000);
        wr16(3'd1, 16'h0005);
        strobe();
        check("R4 wrap down", mem_addr, 24'h07FFFF);
        wr(3'd3, 8'h89);
        strobe();
        check("R4 wrap up", mem_addr, 24'h070000);
        rd16(3'd1, w);
        check("R5 count down", w, 16'h0003);

        // R10 mask port
        wr(3'd4, 8'h05);
        idle();
        check("R10 mask", chan_req, 0);
        wr(3'd4, 8'h01);
        idle();
        check("R10 unmask", chan_req, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule